// File: doc/BRIEF.md
# Compact Harvard 16-bit Processor Core

This block is a small multi-cycle load-store processor. It fetches fixed 24-bit instruction words from a separate program memory and moves 16-bit data to and from its own data memory. Each instruction takes three or four clock cycles: fetch, latch, execute and, for memory reads, a write-back cycle. Both memories are synchronous, with a read latency of one cycle, and sit outside the core.

The core has sixteen register slots. Slot 0 always reads as zero and ignores writes. Slots 1 to 14 are symmetric general-purpose registers, and slot 15 is the stack pointer. An instruction pointer and the negative (N) and zero (Z) flags complete the state. Interrupt priority is resolved outside the core. The core samples a take-interrupt request at each instruction boundary, pushes the instruction pointer and continues at the vector that comes with the request.

Top module: `harv16_core`

## Requirements
- R1: During reset and at its release, the core is not halted, it drives no data write and it presents program address 0. The instruction pointer and registers 1 to 14 reset to 0, and the stack pointer (register 15) resets to 0x0800.
- R2: Immediate forms take the top nibble as the opcode, bits 19:16 as the register and bits 15:0 as the operand. 0x9 is OR, 0xA add, 0xB subtract and 0xC AND, each computing R = R op operand. 0xD loads the operand into R.
- R3: In register forms 0x01 to 0x04 (OR, add, subtract, AND) the word is laid out 0x0k0ABC, and the core computes rA = rB op rC. Forms 0x05, 0x06 and 0x07 complement, shift left by one or logically shift right by one the register named in bits 3:0.
- R4: Every write to a register other than the stack pointer's own adjustment sets N to bit 15 of the written value and sets Z when that value is zero. Stores, jumps, push, call and stop leave both flags unchanged.
- R5: 0xE loads R from the data address in bits 15:0, and 0xF stores R there. 0x2E00AB loads rA from the address held in rB. 0x2F0AB0 stores rA at the address held in rB. 0x2A00AB copies rB into rA.
- R6: The stack grows downward. 0x250R00 decrements the stack pointer and then writes R at the new value. 0x26000R reads at the stack pointer, loads R and then increments the pointer.
- R7: 0x81 jumps to the operand. 0x82 adds the operand, as a signed value, to the address of the next instruction. 0x83 does the same only when N is 1, and 0x84 only when Z is 1. Otherwise they fall through.
- R8: 0x85 pushes the address of the next instruction and jumps to the operand. 0x860000 and 0x870000 pop the instruction pointer from the stack.
- R9: 0x880000 halts the core for good: halted stays high and no further data writes or fetches to a new address take place.
- R10: An unrecognised opcode completes as a no-op, and a write that targets register 0 leaves it reading zero.
- R11: A take-interrupt request seen at an instruction boundary is acknowledged for exactly one cycle. In that cycle the core pushes the address of the instruction it would have fetched, then fetches from the supplied vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 12 | Program memory word address |
| imem_rdata | input | 24 | Instruction word, one cycle after the address |
| dmem_addr | output | 16 | Data memory address |
| dmem_wdata | output | 16 | Data memory write value |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_rdata | input | 16 | Data memory read value, one cycle after the address |
| irq_take | input | 1 | Request to enter an interrupt service routine |
| irq_vector | input | 16 | Service routine start address for the request |
| irq_ack | output | 1 | High in the cycle the request is accepted |
| halted | output | 1 | High once the stop instruction has executed |

## Verification
An interrupt acceptance can fall in the same cycle as the instruction boundary that follows a taken jump or a return. In that cycle the pushed address must be the jump target, not the address of the following word. The bench provokes this by running a one-word loop that jumps to itself. It raises the request at an arbitrary cycle, so acceptance always lands right after a taken jump, and it also returns into the loop from the first service routine. The scoreboard then requires the stacked value to be the loop address, checks that the service routine sees the decremented stack pointer, and counts exactly one acknowledge per request.

// File: rtl/harv16_pkg.sv
// Package: shared types for the compact Harvard core.
// Assumes fixed 24-bit instruction words with 4-bit register fields.
package harv16_pkg;

    localparam int INSTR_W = 24;
    localparam int FIELD_W = 4;
    localparam int IMM_W   = 16;

    typedef enum logic [4:0] {
        OP_NOP, OP_ALU_IMM, OP_ALU_REG, OP_UNARY, OP_LDI, OP_LDD, OP_STD,
        OP_LDR, OP_STR, OP_CPY, OP_PUSH, OP_POP, OP_JMP, OP_JREL, OP_JN,
        OP_JZ, OP_CALL, OP_RET, OP_RETI, OP_STOP
    } op_class_e;

    typedef enum logic [3:0] {
        FN_OR, FN_ADD, FN_SUB, FN_AND, FN_NOT, FN_SHL, FN_SHR, FN_PASSA, FN_PASSB
    } alu_fn_e;

    typedef enum logic [2:0] {
        S_FETCH, S_LATCH, S_EXEC, S_MEM, S_HALT
    } core_state_e;

    typedef struct packed {
        op_class_e            cls;
        alu_fn_e              fn;
        logic [FIELD_W-1:0]   rd;
        logic [FIELD_W-1:0]   ra;
        logic [FIELD_W-1:0]   rb;
        logic [IMM_W-1:0]     imm;
    } ctrl_t;

endpackage

// File: rtl/harv16_decode.sv
// Module: instruction decoder.
// Turns a latched 24-bit word into an operation class, ALU function,
// register selectors and a 16-bit operand. Purely combinational.
// Assumes: unknown encodings map to a no-op.
module harv16_decode
    import harv16_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);

    logic [3:0] top_nib;
    logic [7:0] op_byte;

    assign top_nib = instr[23:20];
    assign op_byte = instr[23:16];

    // Field extraction and opcode classification.
    always_comb begin
        ctrl.cls = OP_NOP;
        ctrl.fn  = FN_PASSA;
        ctrl.rd  = instr[19:16];
        ctrl.ra  = instr[19:16];
        ctrl.rb  = instr[3:0];
        ctrl.imm = instr[15:0];
        case (top_nib)
            4'h9: begin ctrl.cls = OP_ALU_IMM; ctrl.fn = FN_OR;  end
            4'hA: begin ctrl.cls = OP_ALU_IMM; ctrl.fn = FN_ADD; end
            4'hB: begin ctrl.cls = OP_ALU_IMM; ctrl.fn = FN_SUB; end
            4'hC: begin ctrl.cls = OP_ALU_IMM; ctrl.fn = FN_AND; end
            4'hD: begin ctrl.cls = OP_LDI;     ctrl.fn = FN_PASSB; end
            4'hE: ctrl.cls = OP_LDD;
            4'hF: ctrl.cls = OP_STD;
            default: begin
                case (op_byte)
                    8'h01, 8'h02, 8'h03, 8'h04: begin
                        ctrl.cls = OP_ALU_REG;
                        ctrl.rd  = instr[11:8];
                        ctrl.ra  = instr[7:4];
                        ctrl.rb  = instr[3:0];
                        case (op_byte)
                            8'h01:   ctrl.fn = FN_OR;
                            8'h02:   ctrl.fn = FN_ADD;
                            8'h03:   ctrl.fn = FN_SUB;
                            default: ctrl.fn = FN_AND;
                        endcase
                    end
                    8'h05, 8'h06, 8'h07: begin
                        ctrl.cls = OP_UNARY;
                        ctrl.rd  = instr[3:0];
                        ctrl.ra  = instr[3:0];
                        case (op_byte)
                            8'h05:   ctrl.fn = FN_NOT;
                            8'h06:   ctrl.fn = FN_SHL;
                            default: ctrl.fn = FN_SHR;
                        endcase
                    end
                    8'h25: begin ctrl.cls = OP_PUSH; ctrl.ra = instr[11:8]; end
                    8'h26: begin ctrl.cls = OP_POP;  ctrl.rd = instr[3:0];  end
                    8'h2A: begin
                        ctrl.cls = OP_CPY;
                        ctrl.rd  = instr[7:4];
                        ctrl.ra  = instr[3:0];
                    end
                    8'h2E: begin
                        ctrl.cls = OP_LDR;
                        ctrl.rd  = instr[7:4];
                        ctrl.ra  = instr[3:0];
                    end
                    8'h2F: begin
                        ctrl.cls = OP_STR;
                        ctrl.ra  = instr[11:8];
                        ctrl.rb  = instr[7:4];
                    end
                    8'h81: ctrl.cls = OP_JMP;
                    8'h82: ctrl.cls = OP_JREL;
                    8'h83: ctrl.cls = OP_JN;
                    8'h84: ctrl.cls = OP_JZ;
                    8'h85: ctrl.cls = OP_CALL;
                    8'h86: ctrl.cls = OP_RET;
                    8'h87: ctrl.cls = OP_RETI;
                    8'h88: ctrl.cls = OP_STOP;
                    default: ctrl.cls = OP_NOP;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/harv16_alu.sv
// Module: arithmetic and logic unit.
// Two operands in, one result out, no state. Shifts move by one place;
// the right shift fills with zero.
module harv16_alu
    import harv16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_fn_e          fn,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    // Result selection by function code.
    always_comb begin
        case (fn)
            FN_OR:    y = a | b;
            FN_ADD:   y = a + b;
            FN_SUB:   y = a - b;
            FN_AND:   y = a & b;
            FN_NOT:   y = ~a;
            FN_SHL:   y = {a[WIDTH-2:0], 1'b0};
            FN_SHR:   y = {1'b0, a[WIDTH-1:1]};
            FN_PASSB: y = b;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/harv16_regfile.sv
// Module: register file with two read ports and one write port.
// Slot 0 reads as zero and drops writes; the last slot is the stack
// pointer, exposed on its own output and reset to SP_RESET.
module harv16_regfile #(
    parameter int               WIDTH    = 16,
    parameter int               NREGS    = 16,
    parameter logic [WIDTH-1:0] SP_RESET = 16'h0800,
    localparam int              AW       = $clog2(NREGS),
    localparam int              SP_IDX   = NREGS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b,
    output logic [WIDTH-1:0] sp_q
);

    logic [WIDTH-1:0] regs [NREGS];

    // Register storage: reset values, then single-port writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n)
                regs[i] <= (i == SP_IDX) ? SP_RESET : '0;
            else if (we && (waddr == AW'(i)) && (i != 0))
                regs[i] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign sp_q    = regs[SP_IDX];

    // R2/R5: a write to a real register is visible on the next cycle.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

    // R10: slot 0 never holds anything but zero.
    a_r10_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> regs[0] == '0);

endmodule

// File: rtl/harv16_core.sv
// Module: compact Harvard processor core (top).
// Multi-cycle: FETCH presents the instruction pointer, LATCH captures the
// word and advances the pointer, EXEC performs the operation, MEM writes
// back data read from memory. Both memories are synchronous with one cycle
// read latency. An accepted interrupt is taken in FETCH.
module harv16_core
    import harv16_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter int               IADDR_W  = 12,
    parameter int               DADDR_W  = 16,
    parameter int               NREGS    = 16,
    parameter logic [WIDTH-1:0] SP_RESET = 16'h0800,
    localparam int              RA_W     = $clog2(NREGS),
    localparam int              SP_IDX   = NREGS - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [IADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0]  imem_rdata,
    output logic [DADDR_W-1:0]  dmem_addr,
    output logic [WIDTH-1:0]    dmem_wdata,
    output logic                dmem_we,
    output logic                dmem_re,
    input  logic [WIDTH-1:0]    dmem_rdata,
    input  logic                irq_take,
    input  logic [WIDTH-1:0]    irq_vector,
    output logic                irq_ack,
    output logic                halted
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    core_state_e         state, state_n;
    logic [WIDTH-1:0]    ip, ip_next;
    logic                ip_load;
    logic [INSTR_W-1:0]  ir;
    logic                flag_n, flag_z, flag_upd;
    ctrl_t               ctrl;

    logic                rf_we;
    logic [RA_W-1:0]     rf_waddr;
    logic [WIDTH-1:0]    rf_wdata;
    logic [WIDTH-1:0]    rdata_a, rdata_b, sp_q;
    logic [WIDTH-1:0]    alu_b, alu_y, addr_w;

    harv16_decode u_dec (
        .instr (ir),
        .ctrl  (ctrl)
    );

    harv16_regfile #(
        .WIDTH    (WIDTH),
        .NREGS    (NREGS),
        .SP_RESET (SP_RESET)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (RA_W'(ctrl.ra)),
        .rdata_a (rdata_a),
        .raddr_b (RA_W'(ctrl.rb)),
        .rdata_b (rdata_b),
        .sp_q    (sp_q)
    );

    // Second ALU operand: the immediate for immediate forms, else port B.
    assign alu_b = (ctrl.cls == OP_ALU_IMM || ctrl.cls == OP_LDI)
                   ? WIDTH'(ctrl.imm) : rdata_b;

    harv16_alu #(.WIDTH(WIDTH)) u_alu (
        .fn (ctrl.fn),
        .a  (rdata_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign imem_addr = ip[IADDR_W-1:0];
    assign dmem_addr = addr_w[DADDR_W-1:0];
    assign halted    = (state == S_HALT);

    // Control: next state, memory strobes, register and pointer updates.
    always_comb begin
        state_n    = state;
        ip_load    = 1'b0;
        ip_next    = ip;
        rf_we      = 1'b0;
        rf_waddr   = RA_W'(ctrl.rd);
        rf_wdata   = alu_y;
        flag_upd   = 1'b0;
        addr_w     = '0;
        dmem_wdata = '0;
        dmem_we    = 1'b0;
        dmem_re    = 1'b0;
        irq_ack    = 1'b0;
        case (state)
            S_FETCH: begin
                if (irq_take) begin
                    irq_ack    = 1'b1;
                    addr_w     = sp_q - ONE;
                    dmem_wdata = ip;
                    dmem_we    = 1'b1;
                    rf_we      = 1'b1;
                    rf_waddr   = RA_W'(SP_IDX);
                    rf_wdata   = sp_q - ONE;
                    ip_load    = 1'b1;
                    ip_next    = irq_vector;
                end else begin
                    state_n = S_LATCH;
                end
            end
            S_LATCH: state_n = S_EXEC;
            S_EXEC: begin
                state_n = S_FETCH;
                case (ctrl.cls)
                    OP_ALU_IMM, OP_ALU_REG, OP_UNARY, OP_LDI, OP_CPY: begin
                        rf_we    = 1'b1;
                        flag_upd = 1'b1;
                    end
                    OP_LDD: begin
                        addr_w  = WIDTH'(ctrl.imm);
                        dmem_re = 1'b1;
                        state_n = S_MEM;
                    end
                    OP_LDR: begin
                        addr_w  = rdata_a;
                        dmem_re = 1'b1;
                        state_n = S_MEM;
                    end
                    OP_STD: begin
                        addr_w     = WIDTH'(ctrl.imm);
                        dmem_wdata = rdata_a;
                        dmem_we    = 1'b1;
                    end
                    OP_STR: begin
                        addr_w     = rdata_b;
                        dmem_wdata = rdata_a;
                        dmem_we    = 1'b1;
                    end
                    OP_PUSH, OP_CALL: begin
                        addr_w     = sp_q - ONE;
                        dmem_wdata = (ctrl.cls == OP_CALL) ? ip : rdata_a;
                        dmem_we    = 1'b1;
                        rf_we      = 1'b1;
                        rf_waddr   = RA_W'(SP_IDX);
                        rf_wdata   = sp_q - ONE;
                        if (ctrl.cls == OP_CALL) begin
                            ip_load = 1'b1;
                            ip_next = WIDTH'(ctrl.imm);
                        end
                    end
                    OP_POP, OP_RET, OP_RETI: begin
                        addr_w   = sp_q;
                        dmem_re  = 1'b1;
                        rf_we    = 1'b1;
                        rf_waddr = RA_W'(SP_IDX);
                        rf_wdata = sp_q + ONE;
                        state_n  = S_MEM;
                    end
                    OP_JMP: begin
                        ip_load = 1'b1;
                        ip_next = WIDTH'(ctrl.imm);
                    end
                    OP_JREL, OP_JN, OP_JZ: begin
                        ip_next = ip + WIDTH'(ctrl.imm);
                        ip_load = (ctrl.cls == OP_JREL)
                               || (ctrl.cls == OP_JN && flag_n)
                               || (ctrl.cls == OP_JZ && flag_z);
                    end
                    OP_STOP: state_n = S_HALT;
                    default: ;
                endcase
            end
            S_MEM: begin
                state_n = S_FETCH;
                if (ctrl.cls == OP_RET || ctrl.cls == OP_RETI) begin
                    ip_load = 1'b1;
                    ip_next = dmem_rdata;
                end else begin
                    rf_we    = 1'b1;
                    rf_wdata = dmem_rdata;
                    flag_upd = 1'b1;
                end
            end
            default: state_n = S_HALT;
        endcase
    end

    // Sequencer, instruction register and instruction pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
            ip    <= '0;
            ir    <= '0;
        end else begin
            state <= state_n;
            if (state == S_LATCH) begin
                ir <= imem_rdata;
                ip <= ip + ONE;
            end else if (ip_load) begin
                ip <= ip_next;
            end
        end
    end

    // Condition flags follow each flag-updating register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (flag_upd) begin
            flag_n <= rf_wdata[WIDTH-1];
            flag_z <= (rf_wdata == '0);
        end
    end

    // R6/R8/R11: every push-style operation lowers the stack pointer by one.
    a_r6_push_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && (ctrl.cls == OP_PUSH || ctrl.cls == OP_CALL))
        |=> sp_q == $past(sp_q) - ONE);

    // R6: pop raises the stack pointer by one.
    a_r6_pop_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && ctrl.cls == OP_POP) |=> sp_q == $past(sp_q) + ONE);

    // R4: stores and jumps keep the flags.
    a_r4_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && (ctrl.cls == OP_STD || ctrl.cls == OP_STR
                          || ctrl.cls == OP_JMP || ctrl.cls == OP_JREL))
        |=> $stable({flag_n, flag_z}));

    // R9: once halted, stay halted with no data writes.
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !dmem_we && $stable(imem_addr)));

    // R11: after an acknowledge, the fetch address is the vector.
    a_r11_vector_taken: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> imem_addr == $past(irq_vector[IADDR_W-1:0]));

    // R5: a cycle never both reads and writes data memory.
    a_r5_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

endmodule

// File: tb/harv16_core_test.sv
`timescale 1ns/1ps
module harv16_core_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] imem_addr;
    logic [23:0] imem_rdata;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;
    logic        irq_take;
    logic [15:0] irq_vector;
    logic        irq_ack, halted;

    logic [23:0] imem [256];
    logic [15:0] dmem [4096];

    int checks = 0;
    int errors = 0;
    int ack_count = 0;
    logic [15:0] exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_req  [$];

    always #2.5 clk = ~clk;

    harv16_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata),
        .irq_take   (irq_take),
        .irq_vector (irq_vector),
        .irq_ack    (irq_ack),
        .halted     (halted)
    );

    // Synchronous memory models, one cycle read latency.
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:0]];
        dmem_rdata <= dmem[dmem_addr[11:0]];
        if (dmem_we) dmem[dmem_addr[11:0]] <= dmem_wdata;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [15:0] d, input string req);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_req.push_back(req);
    endtask

    // Monitor: every data write is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dmem_we === 1'b1) begin
            if (exp_addr.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 unexpected write actual=%h:%h expected=none",
                         dmem_addr, dmem_wdata);
            end else begin
                logic [15:0] a, d;
                string r;
                a = exp_addr.pop_front();
                d = exp_data.pop_front();
                r = exp_req.pop_front();
                chk(r, "write address", {16'h0, dmem_addr}, {16'h0, a});
                chk(r, "write data", {16'h0, dmem_wdata}, {16'h0, d});
            end
        end
        if (rst_n === 1'b1 && irq_ack === 1'b1) ack_count++;
    end

    task automatic clear_imem();
        for (int i = 0; i < 256; i++) imem[i] = 24'h000000;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_take = 1'b0;
        irq_vector = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "halted in reset", {31'h0, halted}, 32'h0);
        chk("R1", "write in reset", {31'h0, dmem_we}, 32'h0);
        chk("R1", "fetch address in reset", {20'h0, imem_addr}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic raise_irq(input logic [15:0] vec);
        @(posedge clk);
        #1;
        irq_vector = vec;
        irq_take = 1'b1;
        @(posedge clk iff irq_ack);
        #1;
        irq_take = 1'b0;
    endtask

    task automatic wait_halt_and_hold();
        logic [11:0] pc;
        wait (halted === 1'b1);
        @(negedge clk);
        pc = imem_addr;
        repeat (12) @(negedge clk);
        chk("R9", "halt held", {31'h0, halted}, 32'h1);
        chk("R9", "fetch address frozen", {20'h0, imem_addr}, {20'h0, pc});
        chk("R9", "pending writes", exp_addr.size(), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        irq_take = 1'b0;
        irq_vector = 16'h0;
        for (int i = 0; i < 4096; i++) dmem[i] = 16'h0;

        // ---------------- Program A: instruction coverage ----------------
        clear_imem();
        imem[8'h00] = 24'hD11234; imem[8'h01] = 24'hF10100;
        imem[8'h02] = 24'h9100F0; imem[8'h03] = 24'hF10101;
        imem[8'h04] = 24'hA10010; imem[8'h05] = 24'hF10102;
        imem[8'h06] = 24'hB11305; imem[8'h07] = 24'hF10103;
        imem[8'h08] = 24'h830001; imem[8'h09] = 24'hF10104;
        imem[8'h0A] = 24'hC10F0F; imem[8'h0B] = 24'hF10104;
        imem[8'h0C] = 24'hD200FF; imem[8'h0D] = 24'h020312;
        imem[8'h0E] = 24'hF30105; imem[8'h0F] = 24'h030412;
        imem[8'h10] = 24'hF40106; imem[8'h11] = 24'h010512;
        imem[8'h12] = 24'hF50107; imem[8'h13] = 24'h040612;
        imem[8'h14] = 24'hF60108; imem[8'h15] = 24'h050006;
        imem[8'h16] = 24'hF60109; imem[8'h17] = 24'h060006;
        imem[8'h18] = 24'hF6010A; imem[8'h19] = 24'h070006;
        imem[8'h1A] = 24'hF6010B; imem[8'h1B] = 24'hD70200;
        imem[8'h1C] = 24'h2F0670; imem[8'h1D] = 24'h2E0087;
        imem[8'h1E] = 24'hF8010C; imem[8'h1F] = 24'h2A0091;
        imem[8'h20] = 24'hF9010D; imem[8'h21] = 24'hEA0100;
        imem[8'h22] = 24'hFA010E; imem[8'h23] = 24'h250A00;
        imem[8'h24] = 24'h26000B; imem[8'h25] = 24'hFB010F;
        imem[8'h26] = 24'hDC0000; imem[8'h27] = 24'h840001;
        imem[8'h28] = 24'h880000; imem[8'h29] = 24'hFF0110;
        imem[8'h2A] = 24'h850040; imem[8'h2B] = 24'hFF0111;
        imem[8'h2C] = 24'h820002; imem[8'h2D] = 24'h880000;
        imem[8'h2E] = 24'h880000; imem[8'h2F] = 24'h810050;
        imem[8'h40] = 24'hFF0112; imem[8'h41] = 24'hDD0077;
        imem[8'h42] = 24'hFD0113; imem[8'h43] = 24'h860000;
        imem[8'h50] = 24'h123456; imem[8'h51] = 24'hD05555;
        imem[8'h52] = 24'h2A00D0; imem[8'h53] = 24'hFD0114;
        imem[8'h54] = 24'hD10001; imem[8'h55] = 24'hB10001;
        imem[8'h56] = 24'h830005; imem[8'h57] = 24'hF10115;
        imem[8'h58] = 24'h820002; imem[8'h59] = 24'hF20117;
        imem[8'h5A] = 24'h880000; imem[8'h5B] = 24'hD20009;
        imem[8'h5C] = 24'hF20116; imem[8'h5D] = 24'h82FFFB;

        expect_wr(16'h0100, 16'h1234, "R2 load immediate");
        expect_wr(16'h0101, 16'h12F4, "R2 OR immediate");
        expect_wr(16'h0102, 16'h1304, "R2 add immediate");
        expect_wr(16'h0103, 16'hFFFF, "R2 subtract immediate");
        expect_wr(16'h0104, 16'h0F0F, "R4 R7 N kept across store, jump if negative taken; AND immediate");
        expect_wr(16'h0105, 16'h100E, "R3 add register");
        expect_wr(16'h0106, 16'h0E10, "R3 subtract register");
        expect_wr(16'h0107, 16'h0FFF, "R3 OR register");
        expect_wr(16'h0108, 16'h000F, "R3 AND register");
        expect_wr(16'h0109, 16'hFFF0, "R3 complement");
        expect_wr(16'h010A, 16'hFFE0, "R3 shift left");
        expect_wr(16'h010B, 16'h7FF0, "R3 shift right logical");
        expect_wr(16'h0200, 16'h7FF0, "R5 store indirect");
        expect_wr(16'h010C, 16'h7FF0, "R5 load indirect");
        expect_wr(16'h010D, 16'h0F0F, "R5 copy");
        expect_wr(16'h010E, 16'h1234, "R5 load direct");
        expect_wr(16'h07FF, 16'h1234, "R6 push below reset stack pointer");
        expect_wr(16'h010F, 16'h1234, "R6 pop");
        expect_wr(16'h0110, 16'h0800, "R1 R6 stack pointer back at reset value");
        expect_wr(16'h07FF, 16'h002B, "R8 call pushes next address");
        expect_wr(16'h0112, 16'h07FF, "R8 stack pointer inside call");
        expect_wr(16'h0113, 16'h0077, "R8 body of call");
        expect_wr(16'h0111, 16'h0800, "R8 return resumes after call");
        expect_wr(16'h0114, 16'h0000, "R10 unknown opcode skipped, register 0 stays zero");
        expect_wr(16'h0115, 16'h0000, "R7 jump if negative not taken");
        expect_wr(16'h0116, 16'h0009, "R7 relative forward jump");
        expect_wr(16'h0117, 16'h0009, "R7 relative backward jump");

        do_reset();
        wait_halt_and_hold();

        // ---------------- Program B: interrupt at a jump boundary --------
        clear_imem();
        imem[8'h00] = 24'h810000;
        imem[8'h30] = 24'hFF0120; imem[8'h31] = 24'h870000;
        imem[8'h40] = 24'hFF0121; imem[8'h41] = 24'h880000;
        ack_count = 0;
        do_reset();
        repeat (17) @(negedge clk);
        chk("R11", "running before request", {31'h0, halted}, 32'h0);
        chk("R11", "no acknowledge before request", ack_count, 0);

        expect_wr(16'h07FF, 16'h0000, "R11 interrupt pushes jump target");
        expect_wr(16'h0120, 16'h07FF, "R11 service routine sees lowered stack");
        raise_irq(16'h0030);
        repeat (20) @(negedge clk);
        chk("R11", "one acknowledge per request", ack_count, 1);
        chk("R8", "interrupt return pending writes", exp_addr.size(), 0);

        expect_wr(16'h07FF, 16'h0000, "R11 second interrupt after return");
        expect_wr(16'h0121, 16'h07FF, "R11 R8 stack restored by interrupt return");
        raise_irq(16'h0040);
        wait_halt_and_hold();
        chk("R11", "acknowledge total", ack_count, 2);

        summary();
        $finish;
    end

endmodule